// File: doc/BRIEF.md
# Byte-Wide Arithmetic and Shift Unit with Status Flags

This unit computes one arithmetic or shift result per strobe for an 8-bit processor datapath and keeps the processor's status byte. It takes an accumulator value and a data byte. Depending on the selected operation, it adds, subtracts, increments, decrements, shifts or rotates. It then registers the 8-bit result together with the new carry, zero, overflow and negative flags. Whether the result is written back to the accumulator or to memory is decided outside the unit. Shifts, rotates, increment and decrement all act on the data byte.

The carry flag feeds the next operation: it is the carry-in of an add, the not-borrow of a subtract, and the bit shifted into a rotate. Back-to-back strobes therefore chain through the status register without any extra cycle. The status byte also holds four control bits (bits 2 to 5) that no operation touches. The whole byte can be overwritten through a load port.

Top module: `alu8_status`

## Requirements
- R1: While `rst` is high at a clock edge, `status_out`, `res_out` and `res_valid` all become zero.
- R2: Operation code 0 (add) computes the 9-bit sum acc + data + C. `res_out` is the low 8 bits of the sum and C becomes bit 8.
- R3: Operation code 1 (subtract) is the add of R2 with the data byte bitwise inverted. C acts as the not-borrow input and receives bit 8 of the sum.
- R4: For codes 0 and 1, V (bit 6) is set exactly when bit 7 of (acc xor result) and (not (acc xor addend)) is one, where the addend is the data byte or its inverse.
- R5: After every operation, N (bit 7) equals bit 7 of the result and Z (bit 1) is one exactly when the result is zero.
- R6: Code 4 shifts left: old bit 7 goes to C and bit 0 is filled with zero. Code 5 shifts right: old bit 0 goes to C and bit 7 is filled with zero.
- R7: Code 6 rotates left, moving old C into bit 0 and old bit 7 into C. Code 7 rotates right, moving old C into bit 7 and old bit 0 into C.
- R8: Code 2 (increment) and code 3 (decrement) wrap modulo 256 and leave C and V unchanged.
- R9: Codes 4 to 7 leave V unchanged.
- R10: No operation changes status bits 2, 3, 4 and 5.
- R11: A strobe on `op_valid` produces `res_valid` high with the result and updated flags one cycle later. Without a strobe or load, `status_out` holds and `res_valid` is low.
- R12: `st_load` copies `st_wdata` into the status byte at the clock edge and takes priority over a strobe in the same cycle. That strobe is dropped and produces no `res_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Perform the selected operation at this edge |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 inc, 3 dec, 4 shl, 5 shr, 6 rotl, 7 rotr) |
| acc_in | input | 8 | Accumulator value (add/subtract only) |
| data_in | input | 8 | Data byte: addend, subtrahend or unary operand |
| st_load | input | 1 | Overwrite the whole status byte |
| st_wdata | input | 8 | Value for the status load |
| res_valid | output | 1 | Registered result is from the previous strobe |
| res_out | output | 8 | Registered result |
| status_out | output | 8 | Status byte (C0 Z1 I2 D3 B4 U5 V6 N7) |

## Verification
The hardest case to reach from the ports is a long run of back-to-back strobes in which each operation consumes a carry produced by the one before it. An error in carry forwarding only shows when the preceding operation leaves a nonzero carry. The stimulus first presets the status byte through the load port, including the four control bits set to ones. It then issues uninterrupted strobes of mixed operations from a pseudo-random sequence, plus directed operands at the signed-overflow and wrap points. The scoreboard predicts every carry from the previous predicted status.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int ST_W  = 8;
    localparam int BIT_C = 0;
    localparam int BIT_Z = 1;
    localparam int BIT_V = 6;
    localparam int BIT_N = 7;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_INC  = 3'd2,
        OP_DEC  = 3'd3,
        OP_SHL  = 3'd4,
        OP_SHR  = 3'd5,
        OP_ROTL = 3'd6,
        OP_ROTR = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic carry_wr;
        logic ovf;
        logic ovf_wr;
    } flag_upd_t;

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] opnd,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] addend;
    logic [W:0]   wide;

    always_comb begin
        addend = sub ? ~opnd : opnd;
        wide   = {1'b0, acc} + {1'b0, addend} + {{W{1'b0}}, cin};
        sum    = wide[W-1:0];
        cout   = wide[W];
        ovf    = (acc[W-1] == addend[W-1]) && (sum[W-1] != acc[W-1]);
    end
endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] opnd,
    input  logic         cin,
    output logic [W-1:0] value,
    output logic         cout
);
    always_comb begin
        value = opnd;
        cout  = cin;
        unique case (op)
            OP_INC:  value = opnd + {{(W-1){1'b0}}, 1'b1};
            OP_DEC:  value = opnd - {{(W-1){1'b0}}, 1'b1};
            OP_SHL:  begin value = {opnd[W-2:0], 1'b0}; cout = opnd[W-1]; end
            OP_SHR:  begin value = {1'b0, opnd[W-1:1]}; cout = opnd[0];   end
            OP_ROTL: begin value = {opnd[W-2:0], cin};  cout = opnd[W-1]; end
            OP_ROTR: begin value = {cin, opnd[W-1:1]};  cout = opnd[0];   end
            default: begin value = opnd; cout = cin; end
        endcase
    end
endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg
    import alu8_pkg::*;
#(
    parameter logic [ST_W-1:0] RESET_VAL = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [ST_W-1:0] load_val,
    input  logic            upd,
    input  flag_upd_t       fu,
    input  logic            zero,
    input  logic            neg,
    output logic [ST_W-1:0] status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= RESET_VAL;
        end else if (load) begin
            status <= load_val;
        end else if (upd) begin
            status[BIT_Z] <= zero;
            status[BIT_N] <= neg;
            if (fu.carry_wr) status[BIT_C] <= fu.carry;
            if (fu.ovf_wr)   status[BIT_V] <= fu.ovf;
        end
    end

    AST_CTRL_BITS_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!load && upd) |=> (status[5:2] == $past(status[5:2]))); // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!load && !upd) |=> $stable(status)); // R11

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> (status == $past(load_val))); // R12
endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [2:0]      op_sel,
    input  logic [W-1:0]    acc_in,
    input  logic [W-1:0]    data_in,
    input  logic            st_load,
    input  logic [ST_W-1:0] st_wdata,
    output logic            res_valid,
    output logic [W-1:0]    res_out,
    output logic [ST_W-1:0] status_out
);
    alu_op_e   op;
    logic      cin;
    logic      go;
    logic [W-1:0] as_sum, un_val, nxt_val;
    logic      as_cout, as_ovf, un_cout;
    flag_upd_t fu;

    assign op  = alu_op_e'(op_sel);
    assign cin = status_out[BIT_C];
    assign go  = op_valid && !st_load;

    alu8_addsub #(.W(W)) u_addsub (
        .acc (acc_in),
        .opnd(data_in),
        .sub (op == OP_SUB),
        .cin (cin),
        .sum (as_sum),
        .cout(as_cout),
        .ovf (as_ovf)
    );

    alu8_unary #(.W(W)) u_unary (
        .op   (op),
        .opnd (data_in),
        .cin  (cin),
        .value(un_val),
        .cout (un_cout)
    );

    always_comb begin
        if (is_arith(op)) begin
            nxt_val     = as_sum;
            fu.carry    = as_cout;
            fu.carry_wr = 1'b1;
            fu.ovf      = as_ovf;
            fu.ovf_wr   = 1'b1;
        end else begin
            nxt_val     = un_val;
            fu.carry    = un_cout;
            fu.carry_wr = !((op == OP_INC) || (op == OP_DEC));
            fu.ovf      = 1'b0;
            fu.ovf_wr   = 1'b0;
        end
    end

    alu8_status_reg u_status (
        .clk     (clk),
        .rst     (rst),
        .load    (st_load),
        .load_val(st_wdata),
        .upd     (go),
        .fu      (fu),
        .zero    (nxt_val == '0),
        .neg     (nxt_val[W-1]),
        .status  (status_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_out   <= '0;
        end else begin
            res_valid <= go;
            if (go) res_out <= nxt_val;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        go |=> res_valid); // R11

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !go |=> !res_valid); // R12

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (status_out[BIT_Z] == (res_out == '0))); // R5

    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (status_out[BIT_N] == res_out[W-1])); // R5

    AST_INCDEC_CARRY: assert property (@(posedge clk) disable iff (rst)
        (go && (op == OP_INC || op == OP_DEC)) |=>
        (status_out[BIT_C] == $past(status_out[BIT_C]))); // R8

    AST_UNARY_OVF: assert property (@(posedge clk) disable iff (rst)
        (go && !is_arith(op)) |=>
        (status_out[BIT_V] == $past(status_out[BIT_V]))); // R9
endmodule

// File: tb/test_alu8_status.sv
module test_alu8_status;
    import alu8_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] res;
        logic [7:0] st;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [2:0] op_sel;
    logic [7:0] acc_in, data_in, st_wdata;
    logic       st_load;
    logic       res_valid;
    logic [7:0] res_out, status_out;

    int   n_checks = 0;
    int   n_fail   = 0;
    logic [7:0] model_st;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_status i_alu8_status (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .acc_in(acc_in), .data_in(data_in), .st_load(st_load),
        .st_wdata(st_wdata), .res_valid(res_valid), .res_out(res_out),
        .status_out(status_out)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops scoreboard whenever a result appears
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (sb.size() == 0) begin
                check("R11 unexpected res_valid", 16'h1, 16'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {res_out, status_out}, {e.res, e.st});
            end
        end
    end

    // Driver: computes expected from the requirements and drives one strobe
    task automatic apply(logic [2:0] op, logic [7:0] a, logic [7:0] m);
        exp_t e;
        logic [8:0] w;
        logic [7:0] ad, r;
        logic c, v;
        c = model_st[0];
        v = model_st[6];
        case (op)
            3'd0, 3'd1: begin
                ad = (op == 3'd1) ? ~m : m;
                w  = {1'b0, a} + {1'b0, ad} + {8'd0, c};
                r  = w[7:0];
                c  = w[8];
                v  = ((a[7] ^ r[7]) & ~(a[7] ^ ad[7])); // R4
                e.tag = (op == 3'd0) ? "R2/R4 add" : "R3/R4 sub";
            end
            3'd2: begin r = m + 8'd1; e.tag = "R8 inc"; end
            3'd3: begin r = m - 8'd1; e.tag = "R8 dec"; end
            3'd4: begin r = {m[6:0], 1'b0}; c = m[7]; e.tag = "R6/R9 shl"; end
            3'd5: begin r = {1'b0, m[7:1]}; c = m[0]; e.tag = "R6/R9 shr"; end
            3'd6: begin r = {m[6:0], c}; c = m[7]; e.tag = "R7/R9 rotl"; end
            default: begin r = {c, m[7:1]}; c = m[0]; e.tag = "R7/R9 rotr"; end
        endcase
        model_st = {r[7], v, model_st[5:2], (r == 8'd0), c}; // R5 R10
        e.res = r;
        e.st  = model_st;
        sb.push_back(e);
        op_valid = 1'b1;
        op_sel   = op;
        acc_in   = a;
        data_in  = m;
        @(negedge clk);
    endtask

    task automatic idle();
        op_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_status(logic [7:0] val);
        st_load  = 1'b1;
        st_wdata = val;
        @(negedge clk);
        st_load  = 1'b0;
        model_st = val;
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_sel = '0; acc_in = '0;
        data_in = '0; st_load = 1'b0; st_wdata = '0; model_st = '0;
        repeat (3) @(negedge clk);
        check("R1 reset state", {7'd0, res_valid, status_out}, 16'h0000);
        check("R1 reset result", {8'd0, res_out}, 16'h0000);
        rst = 1'b0;
        @(negedge clk);

        // Directed corner cases
        apply(3'd0, 8'h50, 8'h50);   // signed overflow, N
        apply(3'd0, 8'hFF, 8'h01);   // wrap, carry out, Z
        apply(3'd0, 8'h10, 8'h20);   // carry-in from previous
        load_status(8'h01);
        apply(3'd1, 8'h50, 8'hF0);   // borrow
        load_status(8'h01);
        apply(3'd1, 8'hD0, 8'h70);   // sub overflow
        apply(3'd1, 8'h00, 8'h00);
        load_status(8'hFF);          // all control bits set, C and V set
        apply(3'd2, 8'h00, 8'hFF);   // inc wrap, C/V unchanged
        apply(3'd3, 8'h00, 8'h00);   // dec wrap
        apply(3'd4, 8'h00, 8'h81);
        apply(3'd5, 8'h00, 8'h01);
        apply(3'd6, 8'h00, 8'h80);
        apply(3'd7, 8'h00, 8'h01);
        apply(3'd7, 8'h00, 8'h00);
        idle();

        // Idle: status holds, no result (R11)
        data_in = 8'hAA; op_sel = 3'd4;
        repeat (3) @(negedge clk);
        check("R11 idle status hold", {8'd0, status_out}, {8'd0, model_st});
        check("R11 idle no valid", {15'd0, res_valid}, 16'h0);

        // Load together with a strobe: load wins (R12)
        op_valid = 1'b1; op_sel = 3'd0; acc_in = 8'h01; data_in = 8'h01;
        st_load = 1'b1; st_wdata = 8'h3C;
        @(negedge clk);
        st_load = 1'b0; op_valid = 1'b0; model_st = 8'h3C;
        check("R12 load value", {8'd0, status_out}, 16'h003C);
        check("R12 strobe dropped", {15'd0, res_valid}, 16'h0);

        // Pseudo-random chained strobes
        begin
            logic [15:0] lf;
            lf = 16'hACE1;
            for (int i = 0; i < 300; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                apply(lf[2:0], lf[15:8], lf[10:3] ^ 8'h5A);
            end
        end
        idle();
        idle();
        check("R11 scoreboard drained", {8'd0, 8'(sb.size())}, 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule